// File: doc/BRIEF.md
# Prioritized Banked Interrupt Controller

This block collects up to 128 level-sensitive interrupt lines, in banks of 32, and raises one of two processor request outputs: a normal request and a fast request. Each line can be raised by its hardware input or by a software-set bit. Each line can be blocked by a mask bit. Each line carries a 6-bit priority and a routing bit that sends it to one of the two outputs. For each output an arbiter picks the pending line with the best priority and latches its number into an active-line register.

That latched result is frozen. It does not follow later changes in the inputs until software re-arms that output through the control register. Software normally re-arms after it has serviced a line and after it has changed masks. The controller also provides a soft reset with a completion flag, a stored auto-idle bit, a revision word, and per-bank raw and pending views.

The register port is a plain 32-bit word interface with no back-pressure. A write is taken at the clock edge where `bus_wr_i` is high. A read is combinational and returns data for the current `bus_addr_i` in the same cycle. Every access completes in its own cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After hardware reset the block is in this state:
  - every mask bit is 1, and every priority and routing bit is 0;
  - both active-line registers (0x40 for the normal output, 0x44 for the fast output) read 0;
  - status bit 0 at 0x14 reads 1, both outputs are low, and both outputs are armed.
- R2: Each bank b has a register group at 0x80 + 0x20*b. In that group:
  - the mask register at +0x04 is replaced by a write and read back;
  - a 1 written at +0x08 clears that mask bit;
  - a 1 written at +0x0C sets that mask bit;
  - a mask bit of 1 blocks the line. Line i sits in bank i>>5 at bit i&31.
- R3: A 1 written at +0x10 sets a line's software bit, and a 1 written at +0x14 clears it. Both offsets read back the software bits. The raw view at +0x00 reads hardware input OR software bit, and a software bit makes its line pending exactly like its hardware input.
- R4: The pending views are computed per bank:
  - +0x18 reads raw AND NOT mask for lines routed to the normal output;
  - +0x1C reads raw AND NOT mask for lines routed to the fast output.
- R5: The level register of line i is at 0x100 + 4*i. Bit 0 routes the line to the fast output when 1 and to the normal output when 0. Bits 7:2 hold the priority. All other bits read 0.
- R6: Among pending lines, the numerically lowest priority wins, so 0 is the best. On equal priority the lowest line number wins. The winner's number is latched into 0x40 or 0x44 at the next clock edge while that output is armed.
- R7: A latched number does not change until software writes 1 to control bit 0 at 0x48 (normal output) or to control bit 1 (fast output). Such a write re-arms only the selected output, and a fresh result is latched at the following edge.
- R8: An output is high while its latched line is still pending. If the latched line stops being pending, for example because it is masked, the output drops in the same cycle and stays low until that output is re-armed.
- R9: While an output is armed and no line is pending for it, the output is low and its active register keeps its last value. The first edge with a pending line latches it without any control write.
- R10: At the configuration register 0x10:
  - bit 0 is a stored auto-idle bit that reads back and has no effect on arbitration;
  - writing 1 to bit 1 starts a soft reset, during which status bit 0 at 0x14 reads 0 for the one cycle after the write;
  - at the next edge all state returns to the R1 values and the flag reads 1 again.
- R11: Register 0x00 reads the REVISION parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_irq_i | input | NUM_LINES | Level-sensitive hardware interrupt inputs |
| bus_wr_i | input | 1 | Register write strobe, taken at the clock edge |
| bus_addr_i | input | 12 | Byte address of the register access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data for bus_addr_i |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Register writes take effect at the edge that samples them, and reads return the new value in the cycle after that edge. A mask or input change reaches the pending views and drops an output in the same cycle, but a new active-line number appears one edge later. A control write therefore needs a second edge before its arbitration result can be read. The bench does each register write at a falling edge and reads half a cycle after the capturing edge. After a re-arm or a newly pending line it waits one more full cycle before it compares active-line numbers and outputs with its own arithmetic model of masks, routing and priorities. Soft reset is sampled in the cycle right after its write, to see the completion flag at 0, and again one edge later.

// File: rtl/prio_irq_pkg.sv
`timescale 1ns/1ps
package prio_irq_pkg;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned BANK_W  = 32;
  localparam int unsigned PRI_W   = 6;
  localparam int unsigned NUM_OUT = 2;

  localparam logic [ADDR_W-1:0] A_REV       = 12'h000;
  localparam logic [ADDR_W-1:0] A_CFG       = 12'h010;
  localparam logic [ADDR_W-1:0] A_STAT      = 12'h014;
  localparam logic [ADDR_W-1:0] A_ACT_IRQ   = 12'h040;
  localparam logic [ADDR_W-1:0] A_ACT_FIQ   = 12'h044;
  localparam logic [ADDR_W-1:0] A_CTRL      = 12'h048;
  localparam logic [ADDR_W-1:0] A_BANK_BASE = 12'h080;
  localparam logic [ADDR_W-1:0] A_LVL_BASE  = 12'h100;

  // word index inside a bank group; software decodes these offsets
  typedef enum logic [2:0] {
    BR_RAW  = 3'd0,
    BR_MASK = 3'd1,
    BR_MCLR = 3'd2,
    BR_MSET = 3'd3,
    BR_SSET = 3'd4,
    BR_SCLR = 3'd5,
    BR_PIRQ = 3'd6,
    BR_PFIQ = 3'd7
  } bank_reg_e;
endpackage

// File: rtl/prio_irq_bank.sv
`timescale 1ns/1ps
module prio_irq_bank
  import prio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst_i,
  input  logic [BANK_W-1:0] hw_i,
  input  logic              wr_i,
  input  bank_reg_e         reg_i,
  input  logic [BANK_W-1:0] wdata_i,
  input  logic [BANK_W-1:0] route_i,
  output logic [BANK_W-1:0] mask_o,
  output logic [BANK_W-1:0] sw_o,
  output logic [BANK_W-1:0] raw_o,
  output logic [BANK_W-1:0] pend_irq_o,
  output logic [BANK_W-1:0] pend_fiq_o
);
  logic [BANK_W-1:0] mask_q;
  logic [BANK_W-1:0] sw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      sw_q   <= '0;
    end else if (srst_i) begin
      mask_q <= '1;
      sw_q   <= '0;
    end else if (wr_i) begin
      case (reg_i)
        BR_MASK: mask_q <= wdata_i;
        BR_MCLR: mask_q <= mask_q & ~wdata_i;
        BR_MSET: mask_q <= mask_q | wdata_i;
        BR_SSET: sw_q   <= sw_q | wdata_i;
        BR_SCLR: sw_q   <= sw_q & ~wdata_i;
        default: ;
      endcase
    end
  end

  assign mask_o     = mask_q;
  assign sw_o       = sw_q;
  assign raw_o      = hw_i | sw_q;
  assign pend_irq_o = raw_o & ~mask_q & ~route_i;
  assign pend_fiq_o = raw_o & ~mask_q & route_i;
endmodule

// File: rtl/prio_irq_levels.sv
`timescale 1ns/1ps
module prio_irq_levels
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 128,
  parameter int unsigned IDX_W     = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       srst_i,
  input  logic                       wr_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [PRI_W-1:0]           pri_i,
  input  logic                       route_i,
  output logic [NUM_LINES*PRI_W-1:0] pri_o,
  output logic [NUM_LINES-1:0]       route_o
);
  logic [PRI_W-1:0]     pri_q [NUM_LINES];
  logic [NUM_LINES-1:0] route_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LINES; i++) pri_q[i] <= '0;
      route_q <= '0;
    end else if (srst_i) begin
      for (int i = 0; i < NUM_LINES; i++) pri_q[i] <= '0;
      route_q <= '0;
    end else if (wr_i) begin
      pri_q[idx_i]   <= pri_i;
      route_q[idx_i] <= route_i;
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_flat
    assign pri_o[g*PRI_W +: PRI_W] = pri_q[g];
  end
  assign route_o = route_q;
endmodule

// File: rtl/prio_irq_arbiter.sv
`timescale 1ns/1ps
module prio_irq_arbiter
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_IN = 128,
  parameter int unsigned IDX_W  = 7
) (
  input  logic [NUM_IN-1:0]       pend_i,
  input  logic [NUM_IN*PRI_W-1:0] pri_i,
  output logic                    found_o,
  output logic [IDX_W-1:0]        idx_o
);
  localparam int unsigned NB = NUM_IN / BANK_W;

  logic [NB-1:0]    bf;
  logic [PRI_W-1:0] bp [NB];
  logic [IDX_W-1:0] bi [NB];

  // first level: best line inside each bank, lower bit wins a tie
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic             f;
    logic [PRI_W-1:0] p;
    logic [IDX_W-1:0] i;
    always_comb begin
      f = 1'b0;
      p = '1;
      i = '0;
      for (int j = 0; j < BANK_W; j++) begin
        if (pend_i[b*BANK_W+j] &&
            (!f || (pri_i[(b*BANK_W+j)*PRI_W +: PRI_W] < p))) begin
          f = 1'b1;
          p = pri_i[(b*BANK_W+j)*PRI_W +: PRI_W];
          i = IDX_W'(b*BANK_W+j);
        end
      end
    end
    assign bf[b] = f;
    assign bp[b] = p;
    assign bi[b] = i;
  end

  // second level: best bank, lower bank wins a tie
  logic [PRI_W-1:0] best;
  always_comb begin
    found_o = 1'b0;
    best    = '1;
    idx_o   = '0;
    for (int b = 0; b < NB; b++) begin
      if (bf[b] && (!found_o || (bp[b] < best))) begin
        found_o = 1'b1;
        best    = bp[b];
        idx_o   = bi[b];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 128,
  parameter logic [31:0] REVISION  = 32'h0000_0021
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] hw_irq_i,
  input  logic                 bus_wr_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  output logic                 irq_o,
  output logic                 fiq_o
);
  localparam int unsigned NUM_BANKS = NUM_LINES / BANK_W;
  localparam int unsigned IDX_W     = $clog2(NUM_LINES);
  localparam logic [ADDR_W-1:0] BANK_SPAN = ADDR_W'(BANK_W * NUM_BANKS);
  localparam logic [ADDR_W-1:0] LVL_SPAN  = ADDR_W'(4 * NUM_LINES);

  // ---------------- address decode ----------------
  logic [ADDR_W-1:0] bank_off, lvl_off;
  logic              is_bank, is_lvl, wr_cfg, wr_ctrl;
  logic [6:0]        bank_sel;
  bank_reg_e         bank_reg;
  logic [IDX_W-1:0]  lvl_idx;

  assign bank_off = bus_addr_i - A_BANK_BASE;
  assign lvl_off  = bus_addr_i - A_LVL_BASE;
  assign is_bank  = (bus_addr_i >= A_BANK_BASE) && (bank_off < BANK_SPAN) &&
                    (bank_off[1:0] == 2'b00);
  assign is_lvl   = (bus_addr_i >= A_LVL_BASE) && (lvl_off < LVL_SPAN) &&
                    (lvl_off[1:0] == 2'b00);
  assign bank_sel = bank_off[11:5];
  assign bank_reg = bank_reg_e'(bank_off[4:2]);
  assign lvl_idx  = lvl_off[IDX_W+1:2];
  assign wr_cfg   = bus_wr_i && (bus_addr_i == A_CFG);
  assign wr_ctrl  = bus_wr_i && (bus_addr_i == A_CTRL);

  // ---------------- configuration and soft reset ----------------
  logic idle_q, srst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b0;
      srst_q <= 1'b0;
    end else if (srst_q) begin
      idle_q <= 1'b0;
      srst_q <= 1'b0;
    end else if (wr_cfg) begin
      idle_q <= bus_wdata_i[0];
      srst_q <= bus_wdata_i[1];
    end
  end

  // ---------------- per-line level storage ----------------
  logic [NUM_LINES*PRI_W-1:0] pri_all;
  logic [NUM_LINES-1:0]       route_all;

  prio_irq_levels #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_levels (
    .clk     (clk),
    .rst_n   (rst_n),
    .srst_i  (srst_q),
    .wr_i    (bus_wr_i && is_lvl),
    .idx_i   (lvl_idx),
    .pri_i   (bus_wdata_i[7:2]),
    .route_i (bus_wdata_i[0]),
    .pri_o   (pri_all),
    .route_o (route_all)
  );

  // ---------------- banks ----------------
  logic [NUM_LINES-1:0] mask_all, sw_all, raw_all, pend_irq_all, pend_fiq_all;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    prio_irq_bank u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .srst_i     (srst_q),
      .hw_i       (hw_irq_i[b*BANK_W +: BANK_W]),
      .wr_i       (bus_wr_i && is_bank && (bank_sel == 7'(b))),
      .reg_i      (bank_reg),
      .wdata_i    (bus_wdata_i),
      .route_i    (route_all[b*BANK_W +: BANK_W]),
      .mask_o     (mask_all[b*BANK_W +: BANK_W]),
      .sw_o       (sw_all[b*BANK_W +: BANK_W]),
      .raw_o      (raw_all[b*BANK_W +: BANK_W]),
      .pend_irq_o (pend_irq_all[b*BANK_W +: BANK_W]),
      .pend_fiq_o (pend_fiq_all[b*BANK_W +: BANK_W])
    );
  end

  // ---------------- arbitration and freeze, one slice per output ----------------
  logic [NUM_LINES-1:0] pend_sel [NUM_OUT];
  logic [IDX_W-1:0]     num_sel  [NUM_OUT];
  logic [NUM_OUT-1:0]   armed_vec, out_vec;

  assign pend_sel[0] = pend_irq_all;
  assign pend_sel[1] = pend_fiq_all;

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_sel
    logic             armed_q, hold_q, found, rearm;
    logic [IDX_W-1:0] num_q, win;

    prio_irq_arbiter #(.NUM_IN(NUM_LINES), .IDX_W(IDX_W)) u_arb (
      .pend_i  (pend_sel[k]),
      .pri_i   (pri_all),
      .found_o (found),
      .idx_o   (win)
    );

    assign rearm = wr_ctrl && bus_wdata_i[k];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        armed_q <= 1'b1;
        hold_q  <= 1'b0;
        num_q   <= '0;
      end else if (srst_q) begin
        armed_q <= 1'b1;
        hold_q  <= 1'b0;
        num_q   <= '0;
      end else if (rearm) begin
        armed_q <= 1'b1;
        hold_q  <= 1'b0;
      end else if (armed_q && found) begin
        armed_q <= 1'b0;
        hold_q  <= 1'b1;
        num_q   <= win;
      end else if (hold_q && !pend_sel[k][num_q]) begin
        hold_q  <= 1'b0;
      end
    end

    assign armed_vec[k] = armed_q;
    assign out_vec[k]   = hold_q && pend_sel[k][num_q];
    assign num_sel[k]   = num_q;
  end

  logic [IDX_W-1:0] num_irq, num_fiq;
  assign num_irq = num_sel[0];
  assign num_fiq = num_sel[1];
  assign irq_o   = out_vec[0];
  assign fiq_o   = out_vec[1];

  // ---------------- read mux ----------------
  logic [BANK_W-1:0] sel_mask, sel_sw, sel_raw, sel_pirq, sel_pfiq;
  assign sel_mask = mask_all[bank_sel*BANK_W +: BANK_W];
  assign sel_sw   = sw_all[bank_sel*BANK_W +: BANK_W];
  assign sel_raw  = raw_all[bank_sel*BANK_W +: BANK_W];
  assign sel_pirq = pend_irq_all[bank_sel*BANK_W +: BANK_W];
  assign sel_pfiq = pend_fiq_all[bank_sel*BANK_W +: BANK_W];

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == A_REV) begin
      bus_rdata_o = REVISION;
    end else if (bus_addr_i == A_CFG) begin
      bus_rdata_o = {31'b0, idle_q};
    end else if (bus_addr_i == A_STAT) begin
      bus_rdata_o = {31'b0, ~srst_q};
    end else if (bus_addr_i == A_ACT_IRQ) begin
      bus_rdata_o = {{(DATA_W-IDX_W){1'b0}}, num_irq};
    end else if (bus_addr_i == A_ACT_FIQ) begin
      bus_rdata_o = {{(DATA_W-IDX_W){1'b0}}, num_fiq};
    end else if (is_bank) begin
      case (bank_reg)
        BR_RAW:                   bus_rdata_o = sel_raw;
        BR_MASK:                  bus_rdata_o = sel_mask;
        BR_SSET, BR_SCLR:         bus_rdata_o = sel_sw;
        BR_PIRQ:                  bus_rdata_o = sel_pirq;
        BR_PFIQ:                  bus_rdata_o = sel_pfiq;
        default:                  bus_rdata_o = '0;
      endcase
    end else if (is_lvl) begin
      bus_rdata_o = {24'b0, pri_all[lvl_idx*PRI_W +: PRI_W], 1'b0, route_all[lvl_idx]};
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
`timescale 1ns/1ps
module prio_irq_ctrl_chk #(
  parameter int unsigned N     = 128,
  parameter int unsigned IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             srst,
  input logic             irq_o,
  input logic             fiq_o,
  input logic [1:0]       armed,
  input logic [IDX_W-1:0] irq_num,
  input logic [IDX_W-1:0] fiq_num,
  input logic [N-1:0]     mask_all
);
  // R7: a latched number is frozen while its output is not armed
  assert_irq_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed[0] && !srst) |=> $stable(irq_num));
  assert_fiq_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed[1] && !srst) |=> $stable(fiq_num));

  // R8: a request is only shown for a latched result, never while armed
  assert_irq_not_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !armed[0]);
  assert_irq_rise_after_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(armed[0]));

  // R4: routing separates the two outputs, so they never report one line together
  assert_route_split_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && fiq_o) |-> (irq_num != fiq_num));

  // R10: soft reset restores masks and arming, outputs low
  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> ((&mask_all) && (armed == 2'b11) && !irq_o && !fiq_o));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N(NUM_LINES), .IDX_W(IDX_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .srst     (srst_q),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o),
  .armed    (armed_vec),
  .irq_num  (num_irq),
  .fiq_num  (num_fiq),
  .mask_all (mask_all)
);

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  localparam int NL = 128;
  localparam logic [31:0] REV = 32'h0000_0021;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] hw = '0;
  logic          bus_wr = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_o, fiq_o;

  int tests = 0;
  int fails = 0;

  logic [5:0]  m_pri [NL];
  logic        m_rt  [NL];
  logic [31:0] m_mask [4];
  logic [31:0] seed = 32'h1234_5679;
  int prev_irq = 0;
  int prev_fiq = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl #(.NUM_LINES(NL), .REVISION(REV)) dut_i (
    .clk(clk), .rst_n(rst_n), .hw_irq_i(hw), .bus_wr_i(bus_wr),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic logic [11:0] baddr(input int b, input int r);
    return 12'(32'h80 + b * 32 + r * 4);
  endfunction

  function automatic logic [11:0] laddr(input int i);
    return 12'(32'h100 + 4 * i);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic model(input bit fq, output bit f, output int idx);
    int best;
    f = 1'b0; idx = 0; best = 64;
    for (int i = 0; i < NL; i++) begin
      if (hw[i] && !m_mask[i/32][i%32] && (m_rt[i] == fq) && (int'(m_pri[i]) < best)) begin
        f = 1'b1; best = int'(m_pri[i]); idx = i;
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic [31:0] exp_p;
    bit f;
    int idx;
    for (int i = 0; i < NL; i++) begin m_pri[i] = '0; m_rt[i] = 1'b0; end
    for (int b = 0; b < 4; b++) m_mask[b] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R1 reset state, R11 revision
    rd(12'h000, d); chk("R11 revision", d, REV);
    for (int b = 0; b < 4; b++) begin rd(baddr(b, 1), d); chk("R1 mask after reset", d, 32'hFFFF_FFFF); end
    rd(laddr(0), d);   chk("R1 level line 0", d, 0);
    rd(laddr(127), d); chk("R1 level line 127", d, 0);
    rd(12'h040, d); chk("R1 active normal", d, 0);
    rd(12'h044, d); chk("R1 active fast", d, 0);
    rd(12'h014, d); chk("R1 status done", d, 1);
    chk("R1 irq_o low", {31'b0, irq_o}, 0);
    chk("R1 fiq_o low", {31'b0, fiq_o}, 0);

    // R5 level register sweep: priority bits 7:2, route bit 0
    for (int i = 0; i < NL; i++) begin
      m_pri[i] = 6'((i * 37 + 5) % 64);
      m_rt[i]  = (i % 5 == 0);
      wr(laddr(i), {24'b0, m_pri[i], 1'b0, m_rt[i]} | 32'hFFFF_FF02);
    end
    for (int i = 0; i < NL; i++) begin
      rd(laddr(i), d);
      chk("R5 level readback", d, {24'b0, m_pri[i], 1'b0, m_rt[i]});
    end

    // R2 mask write / clear / set
    wr(baddr(1, 1), 32'h0F0F_0F0F); rd(baddr(1, 1), d); chk("R2 mask write", d, 32'h0F0F_0F0F);
    wr(baddr(1, 2), 32'h0000_00FF); rd(baddr(1, 1), d); chk("R2 mask clear", d, 32'h0F0F_0F00);
    wr(baddr(1, 3), 32'hF000_0000); rd(baddr(1, 1), d); chk("R2 mask set", d, 32'hFF0F_0F00);
    m_mask[1] = 32'hFF0F_0F00;

    // R3 software set / clear on bank 2 (masked)
    wr(baddr(2, 4), 32'h0000_0005);
    rd(baddr(2, 4), d); chk("R3 sw set readback", d, 5);
    rd(baddr(2, 5), d); chk("R3 sw readback at clear offset", d, 5);
    rd(baddr(2, 0), d); chk("R3 raw shows sw", d, 5);
    rd(baddr(2, 6), d); chk("R4 masked sw not pending", d, 0);
    wr(baddr(2, 5), 32'h0000_0001);
    rd(baddr(2, 4), d); chk("R3 sw clear", d, 4);
    wr(baddr(2, 2), 32'h0000_0004); m_mask[2] = 32'hFFFF_FFFB;
    rd(baddr(2, 6), d); chk("R3 sw line pending", d, 4);
    tick();
    rd(12'h040, d); chk("R3 sw line latched", d, 66);
    chk("R3 irq_o from sw", {31'b0, irq_o}, 1);
    prev_irq = 66;
    wr(baddr(2, 5), 32'h0000_0004);
    chk("R3 sw cleared drops request", {31'b0, irq_o}, 0);

    // R4 R6 sweep with arithmetic model
    for (int t = 0; t < 40; t++) begin
      hw = '0;
      for (int b = 0; b < 4; b++) begin
        seed = xs(seed); m_mask[b] = seed;
        seed = xs(seed); m_mask[b] = m_mask[b] & seed;
        wr(baddr(b, 1), m_mask[b]);
      end
      if (t % 8 != 7) begin
        for (int b = 0; b < 4; b++) begin
          seed = xs(seed); d = seed;
          seed = xs(seed); hw[b*32 +: 32] = d & seed;
        end
      end
      wr(12'h048, 32'h3);
      tick();
      model(1'b0, f, idx);
      if (f) prev_irq = idx;
      rd(12'h040, d); chk("R6 normal winner", d, 32'(prev_irq));
      chk("R6 irq_o", {31'b0, irq_o}, {31'b0, f});
      model(1'b1, f, idx);
      if (f) prev_fiq = idx;
      rd(12'h044, d); chk("R6 fast winner", d, 32'(prev_fiq));
      chk("R6 fiq_o", {31'b0, fiq_o}, {31'b0, f});
      for (int j = 0; j < 32; j++)
        exp_p[j] = hw[(t%4)*32+j] & ~m_mask[t%4][j] & ~m_rt[(t%4)*32+j];
      rd(baddr(t % 4, 6), d); chk("R4 pending normal", d, exp_p);
      for (int j = 0; j < 32; j++)
        exp_p[j] = hw[(t%4)*32+j] & ~m_mask[t%4][j] & m_rt[(t%4)*32+j];
      rd(baddr(t % 4, 7), d); chk("R4 pending fast", d, exp_p);
    end

    // R7 freeze and tie
    hw = '0;
    for (int b = 0; b < 4; b++) begin wr(baddr(b, 1), 0); m_mask[b] = 0; end
    wr(laddr(40), {24'b0, 6'd20, 2'b00});
    wr(laddr(70), {24'b0, 6'd3, 2'b00});
    wr(laddr(90), {24'b0, 6'd3, 2'b00});
    wr(laddr(5), {24'b0, 6'd3, 2'b00});
    wr(laddr(100), {24'b0, 6'd1, 2'b01});
    hw[40] = 1'b1;
    wr(12'h048, 32'h3); tick();
    rd(12'h040, d); chk("R6 single line", d, 40);
    hw[70] = 1'b1; tick(); tick();
    rd(12'h040, d); chk("R7 frozen without rearm", d, 40);
    chk("R7 irq_o still high", {31'b0, irq_o}, 1);
    wr(12'h048, 32'h1); tick();
    rd(12'h040, d); chk("R7 rearm picks better", d, 70);
    hw[90] = 1'b1; hw[5] = 1'b1;
    wr(12'h048, 32'h1); tick();
    rd(12'h040, d); chk("R6 tie lowest line", d, 5);

    // R8 masking the latched line
    wr(baddr(0, 3), 32'h20);
    chk("R8 masked latched drops", {31'b0, irq_o}, 0);
    rd(12'h040, d); chk("R8 number kept", d, 5);
    wr(baddr(0, 2), 32'h20); tick();
    chk("R8 stays low after unmask", {31'b0, irq_o}, 0);
    wr(12'h048, 32'h1); tick();
    chk("R8 high after rearm", {31'b0, irq_o}, 1);

    // R7 fast rearm leaves normal untouched
    hw[100] = 1'b1;
    wr(12'h048, 32'h2); tick();
    rd(12'h044, d); chk("R7 fast winner", d, 100);
    chk("R7 fiq_o high", {31'b0, fiq_o}, 1);
    rd(12'h040, d); chk("R7 normal untouched", d, 5);

    // R10 auto-idle and soft reset
    wr(12'h010, 32'h1);
    rd(12'h010, d); chk("R10 idle bit readback", d, 1);
    rd(12'h040, d); chk("R10 idle no effect", d, 5);
    wr(12'h010, 32'h2);
    rd(12'h014, d); chk("R10 status busy", d, 0);
    tick();
    rd(12'h014, d); chk("R10 status done", d, 1);
    rd(baddr(0, 1), d); chk("R10 mask restored", d, 32'hFFFF_FFFF);
    rd(laddr(70), d); chk("R10 level cleared", d, 0);
    rd(12'h040, d); chk("R10 active normal cleared", d, 0);
    rd(12'h044, d); chk("R10 active fast cleared", d, 0);
    rd(12'h010, d); chk("R10 idle cleared", d, 0);
    chk("R10 outputs low", {30'b0, irq_o, fiq_o}, 0);

    // R9 armed with nothing pending, then latch without control write
    tick();
    chk("R9 no pending irq_o low", {31'b0, irq_o}, 0);
    rd(12'h040, d); chk("R9 active kept", d, 0);
    wr(baddr(3, 1), 32'h0); tick();
    rd(12'h040, d); chk("R9 latch on first pending", d, 100);
    chk("R9 irq_o high", {31'b0, irq_o}, 1);
    rd(12'h044, d); chk("R9 fast unaffected", d, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule